// File: doc/BRIEF.md
# Limited-Length PWM Timer

This block is a 10-bit up/down counter paired with a 12-bit compare word. Together they drive a single pulse-width-modulated output and two single-cycle interrupt flags. The two top bits of the compare word choose how many low counter bits form the active field: 4, 6, 8 or 10. Each time that field wraps, a PWM period begins. Each time it matches the low bits of the compare word, the pulse ends. In up-count mode the pulse is high; in down-count mode every level is inverted.

The counter bits above the active field keep counting as periods complete. With full-width compare selected, the compare interrupt fires only when all ten counter bits equal the compare word. The counter then freezes in a sticky stopped state. This lets one compare word set both the PWM length and the number of pulses delivered. For example, load 000 and compare C52 in up mode: this gives five pulses, each two cycles long, in 16-cycle periods, and then the counter halts. With limited compare selected, the compare interrupt fires on every active-field match and the PWM runs without end. A new load clears the stopped state.

Top module: `pwm_limit_timer`

## Requirements
- R1: `cmp_word_i[11:10]` selects the active field length: 3 gives 4 bits, 2 gives 6, 1 gives 8 and 0 gives 10. A wrap of the active field is seen when a new count's low field becomes all zeros (up) or all ones (down).
- R2: When `run_i` is 1, the counter is not stopped and `load_i` is 0, the count moves by one per clock: up when `count_up_i` is 1, down when it is 0, modulo 1024. When `run_i` is 0, the count holds.
- R3: A `load_i` pulse places `load_val_i` in the count at the next edge. It clears the stopped state and sets the PWM output to its idle level (0 when counting up, 1 when counting down). Load takes priority over counting.
- R4: In up mode, with compare enabled, a wrap of the active field drives `pwm_o` to 1. A match between the new count's active field and the same bits of the compare word drives it to 0. The output changes in the same cycle as the count that caused it.
- R5: In down mode the levels are inverted: a wrap drives `pwm_o` to 0 and a match drives it to 1.
- R6: While `cmp_en_i` is 0, `pwm_o` is held at the idle level from the next edge, and no compare interrupt and no stop occur.
- R7: `irq_zero_o` is a one-cycle pulse in the cycle that shows the wrapped count. It fires whether or not compare is enabled.
- R8: With `full_cmp_i` at 0, `irq_cmp_o` pulses on every active-field match, the counter never stops, and pulses continue without limit.
- R9: With `full_cmp_i` at 1, `irq_cmp_o` pulses only when all ten count bits equal `cmp_word_i[9:0]`. On that count the counter stops, and `stopped_o` stays at 1 until a load. Load 000 with compare C52 in up mode gives exactly 5 high pulses of 2 cycles each, and the count then stays at 052.
- R10: In down mode with full compare, the upper bits hold the complement of the pulse count. Load 3FF with compare FA2 gives exactly 5 low pulses, and the count then stays at 3A2.
- R11: After reset the count is 0, `pwm_o` is 0, both flags are 0 and `stopped_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Load strobe for the count |
| load_val_i | input | 10 | Value placed in the count on load |
| count_up_i | input | 1 | 1 counts up, 0 counts down |
| run_i | input | 1 | Count enable |
| cmp_en_i | input | 1 | Compare enable; 0 forces the idle PWM level |
| full_cmp_i | input | 1 | 1 selects full ten-bit compare with stop |
| cmp_word_i | input | 12 | Length select [11:10] and compare value [9:0] |
| count_o | output | 10 | Current count |
| pwm_o | output | 1 | PWM output |
| irq_zero_o | output | 1 | One-cycle pulse on active-field wrap |
| irq_cmp_o | output | 1 | One-cycle compare interrupt pulse |
| stopped_o | output | 1 | Counter halted after a full compare |

## Verification
A wrong length decode moves the wrap point. The zero flag and the PWM rising edge then appear on the wrong count within one period of the active field, which is at most 16 cycles for the 4-bit setting. A corrupted upper-bit count, or a missed full match, changes the number of pulses delivered or stops the counter on the wrong value; this becomes visible when the run would otherwise halt. Because the bench compares count, PWM level, both flags and the stop state against its own model on every clock, any wrong state in the count, PWM or stop logic that reaches a port is reported in the cycle it first appears there.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
   typedef struct packed {
      logic wrap;
      logic low_hit;
      logic full_hit;
   } pwmt_evt_t;
endpackage

// File: rtl/pwmt_len_decode.sv
module pwmt_len_decode #(
   parameter int CNT_W    = 10,
   parameter int SEL_W    = 2,
   parameter int LEN_STEP = 2
) (
   input  logic [SEL_W-1:0] sel_i,
   output logic [CNT_W-1:0] mask_o
);
   localparam int N_OPT   = 1 << SEL_W;
   localparam int MIN_LEN = CNT_W - LEN_STEP * (N_OPT - 1);

   if (MIN_LEN < 2) begin : g_bad_len
      $error("shortest active field must have at least 2 bits");
   end

   logic [CNT_W-1:0] opt [N_OPT];

   for (genvar g = 0; g < N_OPT; g++) begin : g_opt
      assign opt[g] = {CNT_W{1'b1}} >> (LEN_STEP * g);
   end

   assign mask_o = opt[sel_i];
endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             up_i,
   input  logic             run_i,
   input  logic             halt_hit_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] nxt_o,
   output logic             adv_o,
   output logic             stopped_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             stopped_q;

   assign adv_o = run_i && !stopped_q && !load_i;
   assign nxt_o = up_i ? cnt_q + 1'b1 : cnt_q - 1'b1;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q     <= '0;
         stopped_q <= 1'b0;
      end else if (load_i) begin
         cnt_q     <= load_val_i;
         stopped_q <= 1'b0;
      end else if (adv_o) begin
         cnt_q <= nxt_o;
         if (halt_hit_i) stopped_q <= 1'b1;
      end
   end

   assign cnt_o     = cnt_q;
   assign stopped_o = stopped_q;

   // R9: a stopped counter holds until a load
   a_r9_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
      (stopped_q && !load_i) |=> $stable(cnt_q));
   // R3: load takes the value and clears the stop
   a_r3_load_takes_value: assert property (@(posedge clk) disable iff (rst)
      load_i |=> (cnt_q == $past(load_val_i)) && !stopped_q);
   // R2: with run low the count does not move
   a_r2_hold_without_run: assert property (@(posedge clk) disable iff (rst)
      (!run_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pwmt_event.sv
module pwmt_event
   import pwmt_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic [CNT_W-1:0] nxt_i,
   input  logic [CNT_W-1:0] mask_i,
   input  logic [CNT_W-1:0] cmp_val_i,
   input  logic             up_i,
   output pwmt_evt_t        evt_o
);
   logic [CNT_W-1:0] low_field;
   assign low_field = nxt_i & mask_i;

   always_comb begin
      evt_o.wrap     = up_i ? (low_field == '0) : (low_field == mask_i);
      evt_o.low_hit  = low_field == (cmp_val_i & mask_i);
      evt_o.full_hit = nxt_i == cmp_val_i;
   end
endmodule

// File: rtl/pwmt_out.sv
module pwmt_out
   import pwmt_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      load_i,
   input  logic      up_i,
   input  logic      cmp_en_i,
   input  logic      full_cmp_i,
   input  logic      adv_i,
   input  pwmt_evt_t evt_i,
   output logic      pwm_o,
   output logic      irq_zero_o,
   output logic      irq_cmp_o,
   output logic      halt_hit_o
);
   logic pwm_q, irq_zero_q, irq_cmp_q, cmp_hit;

   assign cmp_hit    = cmp_en_i && (full_cmp_i ? evt_i.full_hit : evt_i.low_hit);
   assign halt_hit_o = adv_i && cmp_en_i && full_cmp_i && evt_i.full_hit;

   always_ff @(posedge clk) begin
      if (rst) begin
         pwm_q      <= 1'b0;
         irq_zero_q <= 1'b0;
         irq_cmp_q  <= 1'b0;
      end else begin
         irq_zero_q <= adv_i && evt_i.wrap;
         irq_cmp_q  <= adv_i && cmp_hit;
         if (load_i || !cmp_en_i) begin
            pwm_q <= !up_i;
         end else if (adv_i) begin
            if (evt_i.low_hit)   pwm_q <= !up_i;
            else if (evt_i.wrap) pwm_q <= up_i;
         end
      end
   end

   assign pwm_o      = pwm_q;
   assign irq_zero_o = irq_zero_q;
   assign irq_cmp_o  = irq_cmp_q;

   // R6: compare disabled forces the idle level
   a_r6_idle_when_disabled: assert property (@(posedge clk) disable iff (rst)
      !cmp_en_i |=> (pwm_q == !$past(up_i)));
   // R6: compare disabled raises no compare interrupt
   a_r6_no_cmp_irq: assert property (@(posedge clk) disable iff (rst)
      !cmp_en_i |=> !irq_cmp_q);
   // R7: zero flag is a single-cycle pulse
   a_r7_zero_pulse: assert property (@(posedge clk) disable iff (rst)
      irq_zero_q |=> !irq_zero_q);
endmodule

// File: rtl/pwm_limit_timer.sv
module pwm_limit_timer
   import pwmt_pkg::*;
#(
   parameter int CNT_W    = 10,
   parameter int SEL_W    = 2,
   parameter int LEN_STEP = 2
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   load_i,
   input  logic [CNT_W-1:0]       load_val_i,
   input  logic                   count_up_i,
   input  logic                   run_i,
   input  logic                   cmp_en_i,
   input  logic                   full_cmp_i,
   input  logic [SEL_W+CNT_W-1:0] cmp_word_i,
   output logic [CNT_W-1:0]       count_o,
   output logic                   pwm_o,
   output logic                   irq_zero_o,
   output logic                   irq_cmp_o,
   output logic                   stopped_o
);
   localparam int CMP_W = SEL_W + CNT_W;

   logic [CNT_W-1:0] mask, nxt, cmp_val;
   logic             adv, halt_hit;
   pwmt_evt_t        evt;

   assign cmp_val = cmp_word_i[CNT_W-1:0];

   pwmt_len_decode #(.CNT_W(CNT_W), .SEL_W(SEL_W), .LEN_STEP(LEN_STEP)) u_len (
      .sel_i (cmp_word_i[CMP_W-1:CNT_W]),
      .mask_o(mask)
   );

   pwmt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .load_i    (load_i),
      .load_val_i(load_val_i),
      .up_i      (count_up_i),
      .run_i     (run_i),
      .halt_hit_i(halt_hit),
      .cnt_o     (count_o),
      .nxt_o     (nxt),
      .adv_o     (adv),
      .stopped_o (stopped_o)
   );

   pwmt_event #(.CNT_W(CNT_W)) u_evt (
      .nxt_i    (nxt),
      .mask_i   (mask),
      .cmp_val_i(cmp_val),
      .up_i     (count_up_i),
      .evt_o    (evt)
   );

   pwmt_out u_out (
      .clk       (clk),
      .rst       (rst),
      .load_i    (load_i),
      .up_i      (count_up_i),
      .cmp_en_i  (cmp_en_i),
      .full_cmp_i(full_cmp_i),
      .adv_i     (adv),
      .evt_i     (evt),
      .pwm_o     (pwm_o),
      .irq_zero_o(irq_zero_o),
      .irq_cmp_o (irq_cmp_o),
      .halt_hit_o(halt_hit)
   );

   // R1: the zero flag appears only on a count whose active field just wrapped
   a_r1_zero_at_field_edge: assert property (@(posedge clk) disable iff (rst)
      irq_zero_o |-> ((count_o & $past(mask)) ==
                      ($past(count_up_i) ? '0 : $past(mask))));
   // R9: entering the stopped state comes with a compare interrupt
   a_r9_stop_with_irq: assert property (@(posedge clk) disable iff (rst)
      $rose(stopped_o) |-> irq_cmp_o);
endmodule

// File: tb/sim_pwm_limit_timer.sv
module sim_pwm_limit_timer;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ld = 1'b0, up = 1'b1, run = 1'b0, cen = 1'b1, full = 1'b0;
   logic [9:0]  lv = '0;
   logic [11:0] cw = '0;
   logic [9:0]  count;
   logic pwm, iz, ic, stp;

   int n_chk = 0, n_fail = 0;
   bit started = 0;

   always #5 clk = ~clk;

   pwm_limit_timer u0 (
      .clk(clk), .rst(rst), .load_i(ld), .load_val_i(lv), .count_up_i(up),
      .run_i(run), .cmp_en_i(cen), .full_cmp_i(full), .cmp_word_i(cw),
      .count_o(count), .pwm_o(pwm), .irq_zero_o(iz), .irq_cmp_o(ic),
      .stopped_o(stp)
   );

   // behavioural reference
   int m_cnt, m_pwm, m_stop, m_iz, m_ic;
   always @(posedge clk) begin
      int nx, len, msk, low;
      bit wrap, lm, fm;
      started = 1;
      if (rst) begin
         m_cnt = 0; m_pwm = 0; m_stop = 0; m_iz = 0; m_ic = 0;
      end else begin
         m_iz = 0; m_ic = 0;
         if (ld) begin
            m_cnt = lv; m_stop = 0; m_pwm = up ? 0 : 1;
         end else begin
            if (run && !m_stop) begin
               nx   = up ? (m_cnt + 1) % 1024 : (m_cnt + 1023) % 1024;
               len  = 10 - 2 * cw[11:10];
               msk  = (1 << len) - 1;
               low  = nx & msk;
               wrap = up ? (low == 0) : (low == msk);
               lm   = low == (cw[9:0] & msk);
               fm   = nx == cw[9:0];
               if (wrap) m_iz = 1;
               if (cen) begin
                  if (lm) m_pwm = up ? 0 : 1;
                  else if (wrap) m_pwm = up ? 1 : 0;
                  m_ic = full ? fm : lm;
                  if (full && fm) m_stop = 1;
               end
               m_cnt = nx;
            end
            if (!cen) m_pwm = up ? 0 : 1;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) if (started) begin
      chk(count == m_cnt[9:0], "R2 count", count, m_cnt);
      chk(pwm == m_pwm[0], up ? "R4 pwm" : "R5 pwm", pwm, m_pwm);
      chk(iz == m_iz[0], "R7 irq_zero", iz, m_iz);
      chk(ic == m_ic[0], full ? "R9 irq_cmp" : "R8 irq_cmp", ic, m_ic);
      chk(stp == m_stop[0], "R9 stopped", stp, m_stop);
   end

   int rises, falls, hi, zeros;
   logic prev;

   task automatic load_cfg(input logic [9:0] v, input logic u, input logic f,
                           input logic [11:0] w);
      @(negedge clk);
      lv = v; up = u; full = f; cw = w; cen = 1; ld = 1; run = 1;
      @(negedge clk);
      ld = 0;
   endtask

   task automatic run_track(input int n);
      rises = 0; falls = 0; hi = 0; zeros = 0;
      prev = pwm;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pwm && !prev) rises++;
         if (!pwm && prev) falls++;
         if (pwm) hi++;
         if (iz) zeros++;
         prev = pwm;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(count == 0 && pwm == 0 && iz == 0 && ic == 0 && stp == 0,
          "R11 reset", {count, pwm, iz, ic, stp}, 0);
      rst = 0;

      // R9 / R1: five 2-cycle pulses in 4-bit mode, then stop at 052
      load_cfg(10'h000, 1'b1, 1'b1, 12'hC52);
      chk(pwm == 0 && count == 0, "R3 load up", pwm, 0);
      run_track(120);
      chk(rises == 5, "R9 pulse count", rises, 5);
      chk(hi == 10, "R9 pulse width", hi, 10);
      chk(stp == 1 && count == 10'h052, "R9 stop value", count, 10'h052);

      // R2 hold while stopped and with run low
      run = 0;
      repeat (5) @(negedge clk);
      chk(count == 10'h052, "R2 hold", count, 10'h052);

      // R3 load while stopped, switch to down
      up = 0; lv = 10'h3FF; ld = 1;
      @(negedge clk);
      ld = 0;
      chk(stp == 0 && pwm == 1 && count == 10'h3FF, "R3 reload", {stp, pwm}, 2'b01);

      // R10 down, complement pulse count
      load_cfg(10'h3FF, 1'b0, 1'b1, 12'hFA2);
      run_track(120);
      chk(falls == 5, "R10 pulse count", falls, 5);
      chk(stp == 1 && count == 10'h3A2, "R10 stop value", count, 10'h3A2);

      // R8 limited compare runs without limit
      load_cfg(10'h000, 1'b1, 1'b0, 12'hC52);
      run_track(200);
      chk(rises == 12, "R8 unlimited pulses", rises, 12);
      chk(stp == 0, "R8 never stops", stp, 0);

      // R6 compare disabled
      cen = 0;
      @(negedge clk);
      run_track(40);
      chk(hi == 0 && rises == 0, "R6 idle level", hi, 0);

      // R1 6-bit field
      load_cfg(10'h000, 1'b1, 1'b0, 12'h805);
      run_track(140);
      chk(zeros == 2, "R1 6-bit wraps", zeros, 2);
      // R1 8-bit field
      load_cfg(10'h000, 1'b1, 1'b0, 12'h440);
      run_track(300);
      chk(zeros == 1, "R1 8-bit wraps", zeros, 1);
      // R1 10-bit field, down across zero
      load_cfg(10'h010, 1'b0, 1'b0, 12'h005);
      run_track(30);
      chk(zeros == 1, "R1 10-bit wraps", zeros, 1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule